// File: doc/BRIEF.md
# Bank-select address extender

This block sits between a processor bus with a 16-bit address and a physical memory that is wider than 64 KB. It holds a small bank register that the processor loads with an explicit write, either to a decoded I/O port number or to a decoded memory address. A parameter picks which of the two decodes is built. The block forms the physical address by placing the bank register above the 16-bit processor address. Each extra bank bit doubles the number of 64 KB spaces that can be selected, so the default 3-bit register reaches eight of them.

One aligned window of the processor address space is common to every bank. Addresses inside it always go to one fixed physical block, so the code that switches banks and the interrupt handlers stay reachable whatever bank is active. The bank register changes only when it is written. An address or program counter that wraps from 0xFFFF to 0x0000 leaves it alone. The current register value can be read at any time on a readback port.

Top module: `bank_extender`

## Requirements
- R1: While reset is asserted, and after it is released, the bank register holds 0 and `bank_rd` reads 0.
- R2: With `MEM_DECODE`=0, a cycle with `wr_en`=1, `io_req`=1 and `cpu_addr[7:0]`=`IO_PORT` (default 0x40) loads `wr_data` into the bank register at the clock edge that ends the cycle.
- R3: With `MEM_DECODE`=1, a cycle with `wr_en`=1, `mem_req`=1 and `cpu_addr`=`MEM_REG_ADDR` (default 0xEFFF) loads `wr_data` into the bank register at the clock edge that ends the cycle.
- R4: A cycle that does not match the enabled decode leaves the register unchanged. This covers the other cycle type, a different address, and `wr_en`=0.
- R5: A register write first affects `phys_addr` in the cycle after the write. During the write cycle itself, `phys_addr` still uses the old bank value.
- R6: When `cpu_addr[15:COMMON_LOG2]` equals `COMMON_BASE[15:COMMON_LOG2]` (default window 0xF000–0xFFFF), `phys_addr` is `{COMMON_BANK, cpu_addr}` (default `COMMON_BANK`=0), whatever bank is selected.
- R7: Outside the common window, `phys_addr` is `{bank register, cpu_addr}`.
- R8: When the address wraps from 0xFFFF to 0x0000 without a register write, the bank register does not change.
- R9: `bank_rd` always returns the current bank register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address for this bus cycle |
| mem_req | input | 1 | The current cycle is a memory cycle |
| io_req | input | 1 | The current cycle is an I/O port cycle |
| wr_en | input | 1 | The current cycle is a write |
| wr_data | input | BANK_W | Write data for the bank register |
| phys_addr | output | 16+BANK_W | Physical address formed for the current cycle |
| bank_rd | output | BANK_W | Current bank register value |

## Verification
Two instances are driven from the same bus, one built with the port decode and one with the memory decode. The same write therefore loads one instance and must be ignored by the other, which tells the two decodes apart and catches a swapped cycle type. Random traffic is biased toward the two register addresses and mixes hits with near misses and addresses inside the common window. This separates banked composition from the common-window bypass and from the old-versus-new bank timing of the write cycle. Directed sequences cover reset, a sweep of addresses across the 0xFFFF to 0x0000 wrap, and the last and first addresses of the common window.

// File: rtl/bank_extender.sv
module bank_extender #(
  parameter int              BANK_W       = 3,
  parameter bit              MEM_DECODE   = 1'b0,
  parameter logic [7:0]      IO_PORT      = 8'h40,
  parameter logic [15:0]     MEM_REG_ADDR = 16'hEFFF,
  parameter logic [15:0]     COMMON_BASE  = 16'hF000,
  parameter int              COMMON_LOG2  = 12,
  parameter logic [BANK_W-1:0] COMMON_BANK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic                 mem_req,
  input  logic                 io_req,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wr_data,
  output logic [16+BANK_W-1:0] phys_addr,
  output logic [BANK_W-1:0]    bank_rd
);
  localparam int PA_W = 16 + BANK_W;

  logic [BANK_W-1:0] bank_q;
  logic              hit;
  logic              in_common;

  generate
    if (MEM_DECODE) begin : g_mem_dec
      assign hit = wr_en & mem_req & (cpu_addr == MEM_REG_ADDR);
    end else begin : g_io_dec
      assign hit = wr_en & io_req & (cpu_addr[7:0] == IO_PORT);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   bank_q <= '0;
    else if (hit) bank_q <= wr_data;

  assign in_common = (cpu_addr[15:COMMON_LOG2] == COMMON_BASE[15:COMMON_LOG2]);
  assign phys_addr = in_common ? {COMMON_BANK, cpu_addr} : {bank_q, cpu_addr};
  assign bank_rd   = bank_q;

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> bank_rd == '0); // R1
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> bank_rd == $past(wr_data)); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bank_rd)); // R4
  AST_COMMON_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    in_common |-> phys_addr[PA_W-1:16] == COMMON_BANK); // R6
  AST_BANKED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !in_common |-> phys_addr[PA_W-1:16] == bank_rd); // R7
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[15:0] == cpu_addr); // R7
endmodule

// File: tb/tb_bank_extender.sv
module tb_bank_extender;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mem_req = 1'b0, io_req = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_data = '0;
  logic [18:0] pa_io, pa_mem;
  logic [2:0]  rd_io, rd_mem;
  logic [2:0]  m_io, m_mem;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_extender #(.MEM_DECODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req), .io_req(io_req),
    .wr_en(wr_en), .wr_data(wr_data), .phys_addr(pa_io), .bank_rd(rd_io));

  bank_extender #(.MEM_DECODE(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req), .io_req(io_req),
    .wr_en(wr_en), .wr_data(wr_data), .phys_addr(pa_mem), .bank_rd(rd_mem));

  function automatic logic [18:0] exp_pa(logic [2:0] b, logic [15:0] a);
    return (a[15:12] == 4'hF) ? {3'd0, a} : {b, a};
  endfunction

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(logic [15:0] a, logic io, logic mem, logic wr, logic [2:0] d, string req);
    @(negedge clk);
    cpu_addr = a; io_req = io; mem_req = mem; wr_en = wr; wr_data = d;
    #1;
    check({req, " R5/R6/R7 io"}, pa_io, exp_pa(m_io, a));
    check({req, " R5/R6/R7 mem"}, pa_mem, exp_pa(m_mem, a));
    @(posedge clk);
    if (wr && io && a[7:0] == 8'h40) m_io = d;
    if (wr && mem && a == 16'hEFFF) m_mem = d;
    #1;
    check({req, " R9 io"}, {16'd0, rd_io}, {16'd0, m_io});
    check({req, " R9 mem"}, {16'd0, rd_mem}, {16'd0, m_mem});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_io = '0; m_mem = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 io reset", {16'd0, rd_io}, 19'd0);
    check("R1 mem reset", {16'd0, rd_mem}, 19'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 io after release", {16'd0, rd_io}, 19'd0);

    cycle(16'h1240, 1'b1, 1'b0, 1'b1, 3'd5, "R2 io write");
    check("R2 io loaded", {16'd0, rd_io}, 19'd5);
    check("R4 mem ignores io write", {16'd0, rd_mem}, 19'd0);
    cycle(16'hEFFF, 1'b0, 1'b1, 1'b1, 3'd6, "R3 mem write");
    check("R3 mem loaded", {16'd0, rd_mem}, 19'd6);
    check("R4 io ignores mem write", {16'd0, rd_io}, 19'd5);
    cycle(16'h0041, 1'b1, 1'b0, 1'b1, 3'd1, "R4 wrong port");
    cycle(16'h0040, 1'b1, 1'b0, 1'b0, 3'd1, "R4 read not write");
    cycle(16'hEFFE, 1'b0, 1'b1, 1'b1, 3'd1, "R4 wrong mem addr");
    check("R4 io unchanged", {16'd0, rd_io}, 19'd5);
    check("R4 mem unchanged", {16'd0, rd_mem}, 19'd6);
    cycle(16'hF000, 1'b0, 1'b1, 1'b0, 3'd0, "R6 window first");
    cycle(16'hFFFF, 1'b0, 1'b1, 1'b0, 3'd0, "R6 window last");
    cycle(16'hEFFF, 1'b0, 1'b1, 1'b0, 3'd0, "R7 below window");
    for (int i = 0; i < 4; i++)
      cycle(16'hFFFE + 16'(i), 1'b0, 1'b1, 1'b0, 3'd0, "R8 wrap");
    check("R8 io held across wrap", {16'd0, rd_io}, 19'd5);
    check("R8 mem held across wrap", {16'd0, rd_mem}, 19'd6);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int sel;
      logic io;
      a = 16'($urandom);
      sel = $urandom_range(0, 4);
      if (sel == 0) a[7:0] = 8'h40;
      else if (sel == 1) a = 16'hEFFF;
      io = 1'($urandom);
      cycle(a, io, ~io, 1'($urandom), 3'($urandom), "rand");
    end
    finish_run();
  end
endmodule